// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block breaks an application loop of `N` elements into strips that each fit in a vector register holding at most `MAX_VL` elements. After a start pulse it presents one strip at a time, giving the vector length to program for that strip and the index of the strip's first element. The consumer takes the strip with an acknowledge, and the block then presents the following strip.

The short strip comes first. It covers `N mod MAX_VL` elements starting at index 0. Every strip after it covers exactly `MAX_VL` elements, and the block keeps going until all `N` elements are covered. If `N` is an exact multiple of `MAX_VL`, there is no short strip, and the first strip presented is already full length. If `N` is zero, the block presents no strip and reports completion at once.

A sequencer that issues vector instructions would use this block as its loop counter. It reads `stripVl` and `stripBase` for each strip, issues that strip's vector operations, and pulses `stripAck`.

Top module: `stripSequencer`

## Requirements
- R1: After reset, `stripValid` and `done` are both 0.
- R2: If `N mod MAX_VL` is not 0, the first strip appears on the cycle after a start is accepted. It has `stripVl = N mod MAX_VL` and `stripBase = 0`. `MAX_VL` is 64 by default.
- R3: If `N` is a nonzero multiple of `MAX_VL`, the first strip has `stripVl = MAX_VL` and `stripBase = 0`.
- R4: Every strip after the first has `stripVl = MAX_VL`. Its `stripBase` equals the previous strip's `stripBase` plus the previous strip's `stripVl`.
- R5: The block presents exactly `N / MAX_VL` full strips, plus one short strip when the remainder is not 0. On the cycle after the last strip is acknowledged, `stripValid` is 0 and `done` is 1.
- R6: A start with `N = 0` raises `done` on the next cycle, and no strip is ever presented. `stripValid` and `done` are never 1 at the same time.
- R7: While `stripValid` is 1 and `stripAck` is 0, the current strip stays presented and `stripVl` and `stripBase` do not change.
- R8: A start pulse that arrives while a strip is presented is ignored, and the strip sequence continues unchanged.
- R9: `done` stays at 1 until the next start is accepted. A start accepted while `done` is 1 begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only while idle or done |
| lenIn | input | LEN_W (16) | Application length N, unsigned, sampled when a start is accepted |
| stripAck | input | 1 | Consumer takes the presented strip |
| stripVl | output | VL_W (7) | Vector length of the presented strip |
| stripBase | output | LEN_W (16) | Index of the presented strip's first element |
| stripValid | output | 1 | A strip is presented |
| done | output | 1 | All N elements have been covered |

## Verification
Every result is due exactly one clock after the stimulus that causes it. A strip or `done` appears one cycle after the start is accepted. The next strip or `done` appears one cycle after an acknowledge. The bench drives its inputs at the falling edge and checks the outputs at the next falling edge, which is half a period after the single rising edge that registers the result. While an acknowledge is held back, the bench checks at each falling edge that the strip has not changed. Expected lengths and bases come from a bench function that computes the remainder and then accumulates the bases.

// File: rtl/stripSeqPkg.sv
package stripSeqPkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture a new application length
    logic advance;  // step to the next strip
  } seqCtrlT;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EMIT = 2'd1,
    S_DONE = 2'd2
  } seqStateT;

endpackage

// File: rtl/stripSeqDatapath.sv
module stripSeqDatapath
  import stripSeqPkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int MAX_VL = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqCtrlT                       ctrl,
  input  logic [LEN_W-1:0]              lenIn,
  output logic                          lenZero,
  output logic                          lastStrip,
  output logic [$clog2(MAX_VL+1)-1:0]   stripVl,
  output logic [LEN_W-1:0]              stripBase
);

  localparam int VL_W = $clog2(MAX_VL+1);
  localparam bit IS_POW2 = (MAX_VL & (MAX_VL - 1)) == 0;
  localparam logic [LEN_W-1:0] MAX_VL_W = LEN_W'(MAX_VL);

  logic [LEN_W-1:0] remWide;
  logic [LEN_W-1:0] firstVlWide;
  logic [VL_W-1:0]  vlQ;
  logic [LEN_W-1:0] baseQ;
  logic [LEN_W-1:0] leftQ;   // elements remaining after the presented strip

  // Remainder: a mask when the maximum length is a power of two, otherwise a modulo
  generate
    if (IS_POW2) begin : g_remMask
      assign remWide = lenIn & (MAX_VL_W - LEN_W'(1));
    end else begin : g_remMod
      assign remWide = lenIn % MAX_VL_W;
    end
  endgenerate

  assign firstVlWide = (remWide == '0) ? MAX_VL_W : remWide;
  assign lenZero     = (lenIn == '0);
  assign lastStrip   = (leftQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vlQ   <= '0;
      baseQ <= '0;
      leftQ <= '0;
    end else if (ctrl.load) begin
      vlQ   <= VL_W'(firstVlWide);
      baseQ <= '0;
      leftQ <= lenZero ? '0 : (lenIn - firstVlWide);
    end else if (ctrl.advance && !lastStrip) begin
      vlQ   <= VL_W'(MAX_VL);
      baseQ <= baseQ + LEN_W'(vlQ);
      leftQ <= leftQ - MAX_VL_W;
    end
  end

  assign stripVl   = vlQ;
  assign stripBase = baseQ;

endmodule

// File: rtl/stripSeqControl.sv
module stripSeqControl
  import stripSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    stripAck,
  input  logic    lenZero,
  input  logic    lastStrip,
  output seqCtrlT ctrl,
  output logic    stripValid,
  output logic    done
);

  seqStateT stateQ, stateD;
  logic     canStart;

  assign canStart = (stateQ == S_IDLE) || (stateQ == S_DONE);

  always_comb begin
    stateD       = stateQ;
    ctrl.load    = 1'b0;
    ctrl.advance = 1'b0;
    unique case (stateQ)
      S_IDLE, S_DONE: begin
        if (start) begin
          ctrl.load = 1'b1;
          stateD    = lenZero ? S_DONE : S_EMIT;
        end
      end
      S_EMIT: begin
        if (stripAck) begin
          ctrl.advance = 1'b1;
          if (lastStrip) stateD = S_DONE;
        end
      end
      default: stateD = S_IDLE;
    endcase
    if (!canStart && stateQ != S_EMIT) stateD = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign stripValid = (stateQ == S_EMIT);
  assign done       = (stateQ == S_DONE);

endmodule

// File: rtl/stripSequencer.sv
module stripSequencer
  import stripSeqPkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL+1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             stripAck,
  output logic [VL_W-1:0]  stripVl,
  output logic [LEN_W-1:0] stripBase,
  output logic             stripValid,
  output logic             done
);

  seqCtrlT ctrl;
  logic    lenZero;
  logic    lastStrip;

  stripSeqControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .stripAck   (stripAck),
    .lenZero    (lenZero),
    .lastStrip  (lastStrip),
    .ctrl       (ctrl),
    .stripValid (stripValid),
    .done       (done)
  );

  stripSeqDatapath #(.LEN_W(LEN_W), .MAX_VL(MAX_VL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .lenIn     (lenIn),
    .lenZero   (lenZero),
    .lastStrip (lastStrip),
    .stripVl   (stripVl),
    .stripBase (stripBase)
  );

endmodule

// File: rtl/stripSequencerChecker.sv
module stripSequencerChecker #(
  parameter int LEN_W  = 16,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL+1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] lenIn,
  input logic             stripAck,
  input logic [VL_W-1:0]  stripVl,
  input logic [LEN_W-1:0] stripBase,
  input logic             stripValid,
  input logic             done
);

  // R6: never a strip and done together
  p_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(stripValid && done));

  // R6: zero length goes straight to done
  p_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !stripValid && lenIn == '0) |=> (done && !stripValid));

  // R7: strip held without acknowledge
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && !stripAck) |=> (stripValid && $stable(stripVl) && $stable(stripBase)));

  // R4: follow-on strips are full and contiguous
  p_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripAck) |=>
      (!stripValid || (stripVl == VL_W'(MAX_VL) &&
                       stripBase == $past(stripBase) + LEN_W'($past(stripVl)))));

  // R2: presented length is within 1..MAX_VL
  p_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    stripValid |-> (stripVl != '0 && stripVl <= VL_W'(MAX_VL)));

  // R9: done holds until a new start
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

bind stripSequencer stripSequencerChecker #(.LEN_W(LEN_W), .MAX_VL(MAX_VL)) u_chk (.*);

// File: tb/stripSequencer_tb.sv
`timescale 1ns/1ps
module stripSequencer_tb;

  localparam int LEN_W  = 16;
  localparam int MAX_VL = 64;
  localparam int VL_W   = $clog2(MAX_VL+1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] lenIn = '0;
  logic             stripAck = 1'b0;
  logic [VL_W-1:0]  stripVl;
  logic [LEN_W-1:0] stripBase;
  logic             stripValid;
  logic             done;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stripSequencer #(.LEN_W(LEN_W), .MAX_VL(MAX_VL)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // Expected length of strip idx for application length n
  function automatic int expVl(int n, int idx);
    int rem = n % MAX_VL;
    return (idx == 0 && rem != 0) ? rem : MAX_VL;
  endfunction

  function automatic int expStrips(int n);
    return n / MAX_VL + ((n % MAX_VL) != 0 ? 1 : 0);
  endfunction

  task automatic runLen(input int n, input bit pokeStart);
    int base = 0;
    int cnt  = 0;
    @(negedge clk); start = 1'b1; lenIn = LEN_W'(n);
    @(negedge clk); start = 1'b0; lenIn = LEN_W'($urandom);
    if (n == 0) begin
      chk(done == 1'b1 && stripValid == 1'b0, "R6", int'(done), 1);
    end
    while (base < n) begin
      int ev = expVl(n, cnt);
      int waitN = $urandom_range(0, 3);
      chk(stripValid == 1'b1, "R5", int'(stripValid), 1);
      if (cnt == 0 && (n % MAX_VL) == 0)
        chk(int'(stripVl) == ev, "R3", int'(stripVl), ev);
      else if (cnt == 0)
        chk(int'(stripVl) == ev, "R2", int'(stripVl), ev);
      else
        chk(int'(stripVl) == ev, "R4", int'(stripVl), ev);
      chk(int'(stripBase) == base, (cnt == 0) ? "R2" : "R4", int'(stripBase), base);
      for (int w = 0; w < waitN; w++) begin
        if (pokeStart && w == 0) start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(stripValid && int'(stripVl) == ev && int'(stripBase) == base,
            pokeStart ? "R8" : "R7", int'(stripBase), base);
      end
      stripAck = 1'b1;
      @(negedge clk); stripAck = 1'b0;
      base += ev;
      cnt++;
    end
    chk(cnt == expStrips(n), "R5", cnt, expStrips(n));
    chk(done == 1'b1 && stripValid == 1'b0, "R5", int'(done), 1);
    repeat (2) @(negedge clk);
    chk(done == 1'b1, "R9", int'(done), 1);
  endtask

  initial begin
    int directed[9] = '{0, 1, 63, 64, 65, 128, 129, 65472, 65535};
    void'($urandom(32'd20250611));
    #1;
    chk(stripValid == 1'b0 && done == 1'b0, "R1", int'(stripValid), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(stripValid == 1'b0 && done == 1'b0, "R1", int'(done), 0);
    foreach (directed[i]) runLen(directed[i], (i % 2) == 1);
    for (int k = 0; k < 30; k++) runLen(int'($urandom_range(0, 3000)), $urandom_range(0, 1) == 1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule